// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block runs one successive-approximation conversion at a time for a converter with a parameterised resolution (10 bits by default). Software starts a conversion by setting a start/busy bit and can cancel it by clearing that bit. Progress is timed by a clock-enable pulse, `tad_tick`, which marks the end of each conversion clock period. A 3-bit select chooses how many of these periods are spent acquiring the input before the holding switch opens. The sequencer then makes one setup period and one trial per result bit, from the most significant bit down. It drives the trial code to an external DAC and reads back an external comparator.

When a conversion ends, the result is loaded into a high/low register pair, right-justified. In the same cycle the busy bit drops and a sticky interrupt flag rises. A cancelled conversion leaves the result registers as they were. After either outcome the sequencer rests for two periods before it can sample again. A start request that arrives during this rest is kept and served once the rest ends. Software can write the result registers directly while the sequencer is not busy.

Top module: `sar_conv_seq`

## Requirements
- R1: After reset, `busy` and `irq_flag` are 0, both result registers and `dac_code` are 0, and `sh_closed` is 1.
- R2: A `go_set` pulse seen while idle raises `busy` at that clock edge. Acquisition or conversion starts at the next edge, never at the same one.
- R3: `acq_sel` codes 0 to 7 give 0, 2, 4, 6, 8, 12, 16 and 20 acquisition periods. `sh_closed` stays 1 while acquiring.
- R4: A conversion lasts RES_W+1 ticks: one setup period, then one trial per bit from MSB to LSB. After the setup tick, `dac_code` is exactly the MSB (512 for 10 bits). A trial bit is kept when `cmp_in` is 1 (input >= `dac_code`). `sh_closed` is 0 for the whole conversion.
- R5: At the edge that samples the last trial tick, the result is loaded, `busy` falls, `irq_flag` rises and `sh_closed` returns to 1, all together.
- R6: `res_lo` holds result bits [7:0] and `res_hi` holds the upper result bits in its low bits. All remaining `res_hi` bits are 0.
- R7: A `go_clr` pulse during acquisition or conversion drops `busy` at the next edge. It leaves the result registers and `irq_flag` unchanged and closes the switch.
- R8: After completion or cancellation, no new acquisition starts until two ticks have passed. A `go_set` seen during that wait is held, and `busy` rises one edge after the wait ends.
- R9: `irq_flag` stays 1 until an `irq_clr` pulse. A completion in the same cycle as `irq_clr` wins.
- R10: A `res_wr_en` write loads `res_wr_val` when `busy` is 0 and is ignored while `busy` is 1.
- R11: Acquisition and conversion advance only on cycles with `tad_tick` high. Without ticks, `busy` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tad_tick | input | 1 | One-cycle enable that ends a conversion period |
| acq_sel | input | 3 | Automatic acquisition length code |
| go_set | input | 1 | Software sets the start/busy bit |
| go_clr | input | 1 | Software clears the start/busy bit (cancel) |
| irq_clr | input | 1 | Software clears the interrupt flag |
| cmp_in | input | 1 | Comparator: 1 when input >= dac_code |
| res_wr_en | input | 1 | Direct write strobe for the result pair |
| res_wr_val | input | RES_W | Value for a direct write |
| dac_code | output | RES_W | Current trial code to the DAC |
| sh_closed | output | 1 | Sample/hold switch connected to the input |
| busy | output | 1 | Start/busy bit; falls when done or cancelled |
| irq_flag | output | 1 | Sticky completion flag |
| res_hi | output | REG_W | Upper result bits, right-justified |
| res_lo | output | REG_W | Lower result bits |

## Verification
`busy` is due one edge after `go_set`. `sh_closed` reflects the chosen path one edge later. From that edge on, the bench counts the ticks it drives itself. It expects the result, the busy drop and the interrupt exactly at the edge that samples tick number A+11, where A is the acquisition length computed independently for `acq_sel`. Before that edge, it checks every cycle that `busy` is still high and that the switch state matches the tick count. Cancellation is checked one edge after `go_clr`. A start held during the rest is checked one edge after the second rest tick. All outputs are sampled on the falling clock edge, after the registers have settled.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_ACQ  = 2'd1,
      ST_CONV = 2'd2,
      ST_WAIT = 2'd3
   } sar_state_e;

   // Acquisition length in conversion periods for each select code:
   // linear steps of two up to code 4, then steps of four.
   function automatic int unsigned acq_periods(input logic [2:0] code);
      if (code < 3'd5)
         return 2 * int'(code);
      else
         return 4 * (int'(code) - 2);
   endfunction

   localparam int unsigned ACQ_MAX   = 20;
   localparam int unsigned WAIT_TADS = 2;

endpackage

// File: rtl/sar_acq_decode.sv
module sar_acq_decode #(
   parameter int unsigned CNT_W = 5
) (
   input  logic [2:0]       sel,
   output logic [CNT_W-1:0] periods
);
   always_comb begin
      periods = CNT_W'(sar_seq_pkg::acq_periods(sel));
   end
endmodule

// File: rtl/sar_trial_reg.sv
module sar_trial_reg #(
   parameter int unsigned RES_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             step,
   input  logic             cmp_in,
   output logic [RES_W-1:0] trial,
   output logic [RES_W-1:0] decided,
   output logic             last
);
   localparam logic [RES_W-1:0] TOP_BIT = {1'b1, {(RES_W-1){1'b0}}};

   logic [RES_W-1:0] mask_q;
   logic [RES_W-1:0] trial_q;
   logic [RES_W-1:0] keep;

   // Per-bit decision: the bit under trial follows the comparator,
   // every other bit keeps its current value.
   for (genvar i = 0; i < RES_W; i++) begin : g_bit
      assign keep[i] = mask_q[i] ? cmp_in : trial_q[i];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q  <= '0;
         trial_q <= '0;
      end else if (clear) begin
         mask_q  <= '0;
         trial_q <= '0;
      end else if (step) begin
         if (mask_q == '0) begin
            mask_q  <= TOP_BIT;
            trial_q <= TOP_BIT;
         end else begin
            mask_q  <= mask_q >> 1;
            trial_q <= keep | (mask_q >> 1);
         end
      end
   end

   assign trial   = trial_q;
   assign decided = keep;
   assign last    = mask_q[0];
endmodule

// File: rtl/sar_result_regs.sv
module sar_result_regs #(
   parameter int unsigned RES_W = 10,
   parameter int unsigned REG_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_en,
   input  logic [RES_W-1:0] load_val,
   input  logic             wr_en,
   input  logic [RES_W-1:0] wr_val,
   output logic [REG_W-1:0] res_hi,
   output logic [REG_W-1:0] res_lo
);
   localparam int unsigned HI_W = RES_W - REG_W;

   logic [RES_W-1:0] val_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       val_q <= '0;
      else if (load_en) val_q <= load_val;
      else if (wr_en)   val_q <= wr_val;
   end

   assign res_lo = val_q[REG_W-1:0];

   if (HI_W == REG_W) begin : g_hi_full
      assign res_hi = val_q[RES_W-1:REG_W];
   end else begin : g_hi_pad
      assign res_hi = {{(REG_W-HI_W){1'b0}}, val_q[RES_W-1:REG_W]};
   end
endmodule

// File: rtl/sar_conv_seq.sv
module sar_conv_seq #(
   parameter int unsigned RES_W = 10,
   parameter int unsigned REG_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tad_tick,
   input  logic [2:0]       acq_sel,
   input  logic             go_set,
   input  logic             go_clr,
   input  logic             irq_clr,
   input  logic             cmp_in,
   input  logic             res_wr_en,
   input  logic [RES_W-1:0] res_wr_val,
   output logic [RES_W-1:0] dac_code,
   output logic             sh_closed,
   output logic             busy,
   output logic             irq_flag,
   output logic [REG_W-1:0] res_hi,
   output logic [REG_W-1:0] res_lo
);
   import sar_seq_pkg::*;

   localparam int unsigned CNT_MAX = (ACQ_MAX > WAIT_TADS) ? ACQ_MAX : WAIT_TADS;
   localparam int unsigned CNT_W   = $clog2(CNT_MAX + 1);

   if (RES_W <= REG_W || RES_W > 2 * REG_W) begin : g_bad_width
      $error("sar_conv_seq: RES_W must exceed REG_W and fit in two registers");
   end
   if (RES_W < 2) begin : g_bad_res
      $error("sar_conv_seq: RES_W must be at least 2");
   end

   sar_state_e       state_q;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] tgt_q;
   logic [CNT_W-1:0] acq_len;
   logic             busy_q;
   logic             pend_q;
   logic             irq_q;

   logic [RES_W-1:0] trial;
   logic [RES_W-1:0] decided;
   logic             last_bit;
   logic             conv_step;
   logic             done;
   logic             wr_ok;

   sar_acq_decode #(.CNT_W(CNT_W)) i_acq_decode (
      .sel     (acq_sel),
      .periods (acq_len)
   );

   assign conv_step = (state_q == ST_CONV) && tad_tick && !go_clr;
   assign done      = conv_step && last_bit;
   assign wr_ok     = res_wr_en && !busy_q;

   sar_trial_reg #(.RES_W(RES_W)) i_trial (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear   (state_q != ST_CONV),
      .step    (conv_step),
      .cmp_in  (cmp_in),
      .trial   (trial),
      .decided (decided),
      .last    (last_bit)
   );

   sar_result_regs #(.RES_W(RES_W), .REG_W(REG_W)) i_result (
      .clk      (clk),
      .rst_n    (rst_n),
      .load_en  (done),
      .load_val (decided),
      .wr_en    (wr_ok),
      .wr_val   (res_wr_val),
      .res_hi   (res_hi),
      .res_lo   (res_lo)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         cnt_q   <= '0;
         tgt_q   <= '0;
         busy_q  <= 1'b0;
         pend_q  <= 1'b0;
      end else begin
         unique case (state_q)
            ST_IDLE: begin
               if (busy_q) begin
                  if (go_clr) begin
                     busy_q <= 1'b0;
                  end else if (acq_len == '0) begin
                     state_q <= ST_CONV;
                  end else begin
                     state_q <= ST_ACQ;
                     tgt_q   <= acq_len;
                     cnt_q   <= '0;
                  end
               end else if (go_set || pend_q) begin
                  busy_q <= 1'b1;
                  pend_q <= 1'b0;
               end
            end
            ST_ACQ: begin
               if (go_clr) begin
                  busy_q  <= 1'b0;
                  state_q <= ST_WAIT;
                  cnt_q   <= '0;
               end else if (tad_tick) begin
                  if (cnt_q == tgt_q - CNT_W'(1)) state_q <= ST_CONV;
                  cnt_q <= cnt_q + CNT_W'(1);
               end
            end
            ST_CONV: begin
               if (go_clr || done) begin
                  busy_q  <= 1'b0;
                  state_q <= ST_WAIT;
                  cnt_q   <= '0;
               end
            end
            ST_WAIT: begin
               if (go_clr)      pend_q <= 1'b0;
               else if (go_set) pend_q <= 1'b1;
               if (tad_tick) begin
                  if (cnt_q == CNT_W'(WAIT_TADS - 1)) state_q <= ST_IDLE;
                  cnt_q <= cnt_q + CNT_W'(1);
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       irq_q <= 1'b0;
      else if (done)    irq_q <= 1'b1;
      else if (irq_clr) irq_q <= 1'b0;
   end

   assign dac_code  = trial;
   assign sh_closed = (state_q != ST_CONV);
   assign busy      = busy_q;
   assign irq_flag  = irq_q;
endmodule

// File: rtl/sar_seq_checker.sv
module sar_seq_checker #(
   parameter int unsigned RES_W = 10,
   parameter int unsigned REG_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             go_clr,
   input logic             irq_clr,
   input logic             res_wr_en,
   input logic             sh_closed,
   input logic             busy,
   input logic             irq_flag,
   input logic [REG_W-1:0] res_hi,
   input logic [REG_W-1:0] res_lo
);
   // R5: a busy drop that is not a cancellation is a completion
   a_r5_done_sets_irq: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(busy) && !$past(go_clr)) |-> irq_flag);

   // R7: a cancellation never touches the result pair
   a_r7_abort_keeps_result: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(busy) && $past(go_clr)) |-> ($stable(res_hi) && $stable(res_lo)));

   // R4: the switch is open only inside a running conversion
   a_r4_open_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
      !sh_closed |-> busy);

   // R2: nothing opens the switch in the cycle busy rises
   a_r2_no_same_cycle_start: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> sh_closed);

   // R6: unused upper bits of the high register stay zero
   a_r6_hi_padding: assert property (@(posedge clk) disable iff (!rst_n)
      (res_hi >> (RES_W - REG_W)) == '0);

   // R9: the flag is sticky until cleared
   a_r9_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_flag && !irq_clr) |=> irq_flag);

   // R10: a write while busy is dropped if busy is still high afterwards
   a_r10_write_blocked: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(res_wr_en && busy) && busy) |-> ($stable(res_hi) && $stable(res_lo)));
endmodule

bind sar_conv_seq sar_seq_checker #(.RES_W(RES_W), .REG_W(REG_W)) i_sar_seq_checker (
   .clk       (clk),
   .rst_n     (rst_n),
   .go_clr    (go_clr),
   .irq_clr   (irq_clr),
   .res_wr_en (res_wr_en),
   .sh_closed (sh_closed),
   .busy      (busy),
   .irq_flag  (irq_flag),
   .res_hi    (res_hi),
   .res_lo    (res_lo)
);

// File: tb/test_sar_conv_seq.sv
module test_sar_conv_seq;
   localparam int RES_W = 10;
   localparam int REG_W = 8;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             tad_tick = 1'b0;
   logic [2:0]       acq_sel = '0;
   logic             go_set = 1'b0;
   logic             go_clr = 1'b0;
   logic             irq_clr = 1'b0;
   logic             cmp_in;
   logic             res_wr_en = 1'b0;
   logic [RES_W-1:0] res_wr_val = '0;
   logic [RES_W-1:0] dac_code;
   logic             sh_closed;
   logic             busy;
   logic             irq_flag;
   logic [REG_W-1:0] res_hi;
   logic [REG_W-1:0] res_lo;

   logic [RES_W-1:0] ana = '0;
   int tests = 0;
   int fails = 0;
   int tdiv  = 1;
   int phase = 0;
   bit ticked;

   always #5 clk = ~clk;

   assign cmp_in = (ana >= dac_code);

   sar_conv_seq #(.RES_W(RES_W), .REG_W(REG_W)) i_sar_conv_seq (
      .clk(clk), .rst_n(rst_n), .tad_tick(tad_tick), .acq_sel(acq_sel),
      .go_set(go_set), .go_clr(go_clr), .irq_clr(irq_clr), .cmp_in(cmp_in),
      .res_wr_en(res_wr_en), .res_wr_val(res_wr_val), .dac_code(dac_code),
      .sh_closed(sh_closed), .busy(busy), .irq_flag(irq_flag),
      .res_hi(res_hi), .res_lo(res_lo)
   );

   function automatic int acq_len(input int code);
      case (code)
         0: return 0;   1: return 2;   2: return 4;   3: return 6;
         4: return 8;   5: return 12;  6: return 16;  default: return 20;
      endcase
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // drive inputs on the falling edge, step one clock, return on the next falling edge
   task automatic step();
      tad_tick = (phase == 0);
      phase = (phase + 1) % tdiv;
      @(posedge clk);
      ticked = tad_tick;
      @(negedge clk);
   endtask

   task automatic chk_result(input int v, input string req);
      chk(res_hi == REG_W'(v >> 8), req, int'(res_hi), v >> 8);
      chk(res_lo == REG_W'(v & 255), req, int'(res_lo), v & 255);
   endtask

   task automatic issue_go();
      go_set = 1'b1;
      step();
      go_set = 1'b0;
      chk(busy == 1'b1, "R2", int'(busy), 1);
   endtask

   // follows a conversion from the edge after busy rose to completion
   task automatic track(input int v, input int sel);
      int a = acq_len(sel);
      int need = a + RES_W + 1;
      int n = 0;
      step();
      chk(sh_closed == (a != 0), "R2", int'(sh_closed), int'(a != 0));
      while (n < need) begin
         step();
         if (ticked) n++;
         if (n < need) begin
            chk(busy == 1'b1, "R11", int'(busy), 1);
            chk(sh_closed == (n < a), (n < a) ? "R3" : "R4", int'(sh_closed), int'(n < a));
            if (ticked && n == a + 1)
               chk(dac_code == RES_W'(512), "R4", int'(dac_code), 512);
         end
      end
      chk(busy == 1'b0, "R5", int'(busy), 0);
      chk(irq_flag == 1'b1, "R5", int'(irq_flag), 1);
      chk(sh_closed == 1'b1, "R5", int'(sh_closed), 1);
      chk_result(v, "R4");
   endtask

   task automatic convert(input int v, input int sel);
      ana = RES_W'(v);
      acq_sel = 3'(sel);
      issue_go();
      track(v, sel);
   endtask

   task automatic rest_two(input bit expect_busy_after);
      int m = 0;
      while (m < 2) begin
         step();
         if (ticked) m++;
         chk(busy == 1'b0, "R8", int'(busy), 0);
      end
      step();
      chk(busy == expect_busy_after, "R8", int'(busy), int'(expect_busy_after));
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      chk(busy == 1'b0, "R1", int'(busy), 0);
      chk(irq_flag == 1'b0, "R1", int'(irq_flag), 0);
      chk(sh_closed == 1'b1, "R1", int'(sh_closed), 1);
      chk(dac_code == '0, "R1", int'(dac_code), 0);
      chk_result(0, "R1");
      rst_n = 1'b1;
      step();

      // direct write while idle, right-justified split
      res_wr_en = 1'b1; res_wr_val = 10'h2A5;
      step();
      res_wr_en = 1'b0;
      chk_result(32'h2A5, "R10");
      chk(res_hi == 8'h02, "R6", int'(res_hi), 2);

      // directed corner values
      tdiv = 1; phase = 0;
      convert(1023, 0);
      rest_two(1'b0);
      convert(0, 2);
      rest_two(1'b0);
      tdiv = 3; phase = 0;
      convert(512, 1);
      rest_two(1'b0);

      // every acquisition code
      for (int s = 0; s < 8; s++) begin
         tdiv = 1 + int'($urandom_range(3)); phase = 0;
         convert(int'($urandom_range(1023)), s);
         rest_two(1'b0);
      end

      // sticky flag, clear
      repeat (5) step();
      chk(irq_flag == 1'b1, "R9", int'(irq_flag), 1);
      irq_clr = 1'b1; step(); irq_clr = 1'b0;
      chk(irq_flag == 1'b0, "R9", int'(irq_flag), 0);

      // cancellation mid-conversion with a blocked write
      tdiv = 2; phase = 0;
      res_wr_en = 1'b1; res_wr_val = 10'h155; step(); res_wr_en = 1'b0;
      ana = 10'd777; acq_sel = 3'd1;
      issue_go();
      begin
         int n = 0;
         step();
         res_wr_en = 1'b1; res_wr_val = 10'h0F0;
         step();
         res_wr_en = 1'b0;
         if (ticked) n++;
         chk(busy == 1'b1, "R10", int'(busy), 1);
         chk_result(32'h155, "R10");
         while (n < 5) begin step(); if (ticked) n++; end
      end
      go_clr = 1'b1; step(); go_clr = 1'b0;
      chk(busy == 1'b0, "R7", int'(busy), 0);
      chk(irq_flag == 1'b0, "R7", int'(irq_flag), 0);
      chk(sh_closed == 1'b1, "R7", int'(sh_closed), 1);
      chk_result(32'h155, "R7");
      rest_two(1'b0);
      chk_result(32'h155, "R7");

      // start request held through the rest
      tdiv = 2; phase = 0;
      convert(300, 0);
      go_set = 1'b1; step(); go_set = 1'b0;
      chk(busy == 1'b0, "R8", int'(busy), 0);
      rest_two(1'b1);
      ana = 10'd45; acq_sel = 3'd3;
      track(45, 3);
      rest_two(1'b0);

      // long tick spacing: no progress between ticks
      tdiv = 9; phase = 0;
      convert(int'($urandom_range(1023)), 4);
      rest_two(1'b0);

      // random mix
      for (int k = 0; k < 12; k++) begin
         tdiv = 1 + int'($urandom_range(4)); phase = 0;
         convert(int'($urandom_range(1023)), int'($urandom_range(7)));
         rest_two(1'b0);
      end

      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule